// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block watches the ISA I/O bus for a small set of logical devices. Each device owns an eight-byte I/O window. The window's base is programmed by a configuration pair and has an activate bit of its own. On an I/O read or write that falls inside an active window, the block asserts that device's chip select and passes on the low three address bits as a register offset. While the bus is in a DMA cycle, I/O decode is held off. DMA acknowledge and terminal count are then steered to the device that owns the acknowledged channel.

Each device's interrupt request is steered to a selectable interrupt line, and its DMA request to a selectable DMA channel. A select value of zero leaves the device unrouted. Each device also has a card-present input whose active level is set by a polarity bit. Every output is registered, so it follows the bus inputs by one clock.

Top module: `isa_window_decoder`

## Requirements
- R1: The chip select of a device rises one clock after its window is hit. A hit needs I/O read or write low, AEN low, and address bits 11:3 equal to bits 11:3 of the 16-bit base {hi,lo}. `reg_off` then carries address bits 2:0.
- R2: A device whose activate bit is 0 never asserts its chip select, its DMA acknowledge or terminal count, or any interrupt or DMA line.
- R3: While AEN is high, no chip select is asserted and `io_rd`/`io_wr` stay low.
- R4: A base below 0x100 or above 0xFFF disables the window. Base bits 2:0 are ignored.
- R5: When windows overlap, only the lowest-numbered hitting device is selected, so at most one chip select is high.
- R6: `io_rd` is high one clock after a hit with IOR# low. `io_wr` is high one clock after a hit with IOW# low.
- R7: Interrupt line k (1..15) is high when some active device has its 4-bit IRQ select equal to k and its request high. Line 0 is never driven.
- R8: DMA channel k (1..7) is high when some active device has its 4-bit DRQ select equal to k and its request high. A select of 0 or of 8 and above drives nothing.
- R9: `dma_ack[i]` is high one clock after AEN is high and the DACK# bit of device i's valid, nonzero channel is low. `dma_tc[i]` is `dma_ack[i]` qualified by TC.
- R10: `card_present[i]` follows the raw input when the polarity bit is 0. It follows the inverted input when the bit is 1.
- R11: During synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | ISA I/O address |
| bus_aen | input | 1 | Address enable, high in DMA cycles |
| bus_ior_n | input | 1 | I/O read strobe, active low |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_dack_n | input | 8 | DMA acknowledge per channel, active low |
| bus_tc | input | 1 | DMA terminal count |
| cfg_base_hi | input | 3x8 | Base address high byte per device |
| cfg_base_lo | input | 3x8 | Base address low byte per device |
| cfg_active | input | 3 | Activate bit per device |
| cfg_irq_sel | input | 3x4 | Interrupt line select per device |
| cfg_drq_sel | input | 3x4 | DMA channel select per device |
| cfg_psnt_pol | input | 3 | Card-present polarity per device |
| dev_irq | input | 3 | Interrupt request per device |
| dev_drq | input | 3 | DMA request per device |
| card_raw | input | 3 | Raw card-present input per device |
| cs | output | 3 | Chip select per device |
| reg_off | output | 3 | Register offset within the window |
| io_rd | output | 1 | Qualified read strobe |
| io_wr | output | 1 | Qualified write strobe |
| irq_line | output | 16 | Routed interrupt lines |
| drq_line | output | 8 | Routed DMA request lines |
| dma_ack | output | 3 | DMA acknowledge per device |
| dma_tc | output | 3 | Terminal count per device |
| card_present | output | 3 | Qualified card-present per device |

## Verification
A wrong window compare or range check shows up as a missing or extra chip select one clock after the bus cycle. Such an error is caught on the first random access that lands on or near a base. A broken AEN gate leaks a chip select during DMA, or loses a DMA acknowledge, in that same clock. A mis-indexed route drives the wrong interrupt or DMA line. The line comparison exposes this on the next cycle in which that request is high.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int WIN_ALIGN = 3;            // 8-byte windows
  localparam logic [15:0] BASE_MIN = 16'h0100;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] line_sel_t;
endpackage

// File: rtl/isa_win_match.sv
module isa_win_match
  import isa_dec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        base_hi,
  input  logic [7:0]        base_lo,
  input  logic              active,
  input  logic              aen,
  input  logic              io_cycle,
  output logic              hit
);
  localparam logic [15:0] BASE_MAX = 16'((1 << ADDR_W) - 1);

  logic [15:0] base;
  logic        in_range;
  logic        addr_eq;

  always_comb begin
    base     = {base_hi, base_lo};
    in_range = (base >= BASE_MIN) && (base <= BASE_MAX);
    addr_eq  = addr[ADDR_W-1:WIN_ALIGN] == base[ADDR_W-1:WIN_ALIGN];
    hit      = active && in_range && !aen && io_cycle && addr_eq;
  end
endmodule

// File: rtl/isa_line_router.sv
module isa_line_router
  import isa_dec_pkg::*;
#(
  parameter int NDEV  = 3,
  parameter int LINES = 16
) (
  input  logic [NDEV-1:0]            req,
  input  logic [NDEV-1:0]            en,
  input  logic [NDEV-1:0][SEL_W-1:0] sel,
  output logic [LINES-1:0]           line
);
  always_comb begin
    line = '0;
    for (int k = 1; k < LINES; k++) begin
      for (int i = 0; i < NDEV; i++) begin
        if (en[i] && req[i] && (32'(sel[i]) == k)) line[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/isa_window_decoder.sv
module isa_window_decoder
  import isa_dec_pkg::*;
#(
  parameter int NDEV      = 3,
  parameter int ADDR_W    = 12,
  parameter int IRQ_LINES = 16,
  parameter int DRQ_CHANS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_aen,
  input  logic                       bus_ior_n,
  input  logic                       bus_iow_n,
  input  logic [DRQ_CHANS-1:0]       bus_dack_n,
  input  logic                       bus_tc,
  input  logic [NDEV-1:0][7:0]       cfg_base_hi,
  input  logic [NDEV-1:0][7:0]       cfg_base_lo,
  input  logic [NDEV-1:0]            cfg_active,
  input  logic [NDEV-1:0][SEL_W-1:0] cfg_irq_sel,
  input  logic [NDEV-1:0][SEL_W-1:0] cfg_drq_sel,
  input  logic [NDEV-1:0]            cfg_psnt_pol,
  input  logic [NDEV-1:0]            dev_irq,
  input  logic [NDEV-1:0]            dev_drq,
  input  logic [NDEV-1:0]            card_raw,
  output logic [NDEV-1:0]            cs,
  output logic [WIN_ALIGN-1:0]       reg_off,
  output logic                       io_rd,
  output logic                       io_wr,
  output logic [IRQ_LINES-1:0]       irq_line,
  output logic [DRQ_CHANS-1:0]       drq_line,
  output logic [NDEV-1:0]            dma_ack,
  output logic [NDEV-1:0]            dma_tc,
  output logic [NDEV-1:0]            card_present
);
  localparam int CH_W = $clog2(DRQ_CHANS);

  logic [NDEV-1:0]      hit;
  logic [NDEV-1:0]      cs_d;
  logic [NDEV-1:0]      ack_d;
  logic [IRQ_LINES-1:0] irq_d;
  logic [DRQ_CHANS-1:0] drq_d;
  logic                 io_cycle;

  assign io_cycle = !bus_ior_n || !bus_iow_n;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    isa_win_match #(.ADDR_W(ADDR_W)) u_match (
      .addr     (bus_addr),
      .base_hi  (cfg_base_hi[g]),
      .base_lo  (cfg_base_lo[g]),
      .active   (cfg_active[g]),
      .aen      (bus_aen),
      .io_cycle (io_cycle),
      .hit      (hit[g])
    );

    logic ch_ok;
    assign ch_ok    = (cfg_drq_sel[g] != '0) && (32'(cfg_drq_sel[g]) < DRQ_CHANS);
    assign ack_d[g] = cfg_active[g] && bus_aen && ch_ok &&
                      !bus_dack_n[cfg_drq_sel[g][CH_W-1:0]];

    // R2: an inactive device is never selected on the next cycle
    p_inactive_silent_r2: assert property (@(posedge clk) disable iff (rst)
      !cfg_active[g] |=> !cs[g] && !dma_ack[g]);
  end

  // R5: lowest index wins among overlapping windows
  always_comb begin
    cs_d = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (hit[i]) cs_d = NDEV'(1) << i;
    end
  end

  isa_line_router #(.NDEV(NDEV), .LINES(IRQ_LINES)) u_irq_route (
    .req (dev_irq), .en (cfg_active), .sel (cfg_irq_sel), .line (irq_d)
  );

  isa_line_router #(.NDEV(NDEV), .LINES(DRQ_CHANS)) u_drq_route (
    .req (dev_drq), .en (cfg_active), .sel (cfg_drq_sel), .line (drq_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs           <= '0;
      reg_off      <= '0;
      io_rd        <= 1'b0;
      io_wr        <= 1'b0;
      irq_line     <= '0;
      drq_line     <= '0;
      dma_ack      <= '0;
      dma_tc       <= '0;
      card_present <= '0;
    end else begin
      cs           <= cs_d;
      reg_off      <= bus_addr[WIN_ALIGN-1:0];
      io_rd        <= (|hit) && !bus_ior_n;
      io_wr        <= (|hit) && !bus_iow_n;
      irq_line     <= irq_d;
      drq_line     <= drq_d;
      dma_ack      <= ack_d;
      dma_tc       <= ack_d & {NDEV{bus_tc}};
      card_present <= card_raw ^ cfg_psnt_pol;
    end
  end

  // R5: never more than one chip select
  p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(cs));
  // R3: AEN high blocks I/O decode
  p_no_cs_in_dma_r3: assert property (@(posedge clk) disable iff (rst)
    bus_aen |=> (cs == '0) && !io_rd && !io_wr);
  // R9: a DMA acknowledge only follows a DMA cycle
  p_ack_needs_aen_r9: assert property (@(posedge clk) disable iff (rst)
    (dma_ack != '0) |-> $past(bus_aen));
  // R9: terminal count only on an acknowledged device
  p_tc_subset_r9: assert property (@(posedge clk) disable iff (rst)
    (dma_tc & ~dma_ack) == '0);
  // R6: strobes only with a selected device
  p_strobe_needs_cs_r6: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> (cs != '0));
endmodule

// File: tb/isa_window_decoder_tb.sv
module isa_window_decoder_tb;
  localparam int N = 3;

  logic clk = 0;
  logic rst = 1;
  always #10 clk = ~clk;

  logic [11:0] addr = '0;
  logic aen = 0, ior_n = 1, iow_n = 1, tc = 0;
  logic [7:0] dack_n = '1;
  logic [N-1:0][7:0] bh = '0, bl = '0;
  logic [N-1:0] act = '0, pol = '0, dirq = '0, ddrq = '0, craw = '0;
  logic [N-1:0][3:0] isel = '0, dsel = '0;

  logic [N-1:0] cs, dma_ack, dma_tc, card_present;
  logic [2:0] reg_off;
  logic io_rd, io_wr;
  logic [15:0] irq_line;
  logic [7:0] drq_line;

  int checks = 0, errors = 0;
  bit done = 0;

  isa_window_decoder u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_aen(aen), .bus_ior_n(ior_n),
    .bus_iow_n(iow_n), .bus_dack_n(dack_n), .bus_tc(tc),
    .cfg_base_hi(bh), .cfg_base_lo(bl), .cfg_active(act), .cfg_irq_sel(isel),
    .cfg_drq_sel(dsel), .cfg_psnt_pol(pol), .dev_irq(dirq), .dev_drq(ddrq),
    .card_raw(craw), .cs(cs), .reg_off(reg_off), .io_rd(io_rd), .io_wr(io_wr),
    .irq_line(irq_line), .drq_line(drq_line), .dma_ack(dma_ack),
    .dma_tc(dma_tc), .card_present(card_present)
  );

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] e_cs();
    logic [N-1:0] r = '0;
    bit found = 0;
    for (int i = 0; i < N; i++) begin
      logic [15:0] b = {bh[i], bl[i]};
      if (!found && act[i] && b >= 16'h100 && b <= 16'hFFF && !aen &&
          (!ior_n || !iow_n) && addr[11:3] == b[11:3]) begin
        r[i] = 1; found = 1;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] e_irq();
    logic [15:0] r = '0;
    for (int i = 0; i < N; i++)
      if (act[i] && dirq[i] && isel[i] != 0) r[isel[i]] = 1;
    return r;
  endfunction

  function automatic logic [7:0] e_drq();
    logic [7:0] r = '0;
    for (int i = 0; i < N; i++)
      if (act[i] && ddrq[i] && dsel[i] != 0 && dsel[i] < 8) r[dsel[i][2:0]] = 1;
    return r;
  endfunction

  function automatic logic [N-1:0] e_ack();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (act[i] && aen && dsel[i] != 0 && dsel[i] < 8 && !dack_n[dsel[i][2:0]])
        r[i] = 1;
    return r;
  endfunction

  task automatic check_all(string tag);
    logic [N-1:0] c = e_cs();
    logic [N-1:0] k = e_ack();
    chk({tag, " R1 cs"}, 32'(cs), 32'(c));
    chk({tag, " R1 reg_off"}, 32'(reg_off), 32'(addr[2:0]));
    chk({tag, " R6 rd"}, 32'(io_rd), 32'((|c) && !ior_n));
    chk({tag, " R6 wr"}, 32'(io_wr), 32'((|c) && !iow_n));
    chk({tag, " R7 irq"}, 32'(irq_line), 32'(e_irq()));
    chk({tag, " R8 drq"}, 32'(drq_line), 32'(e_drq()));
    chk({tag, " R9 ack"}, 32'(dma_ack), 32'(k));
    chk({tag, " R9 tc"}, 32'(dma_tc), 32'(k & {N{tc}}));
    chk({tag, " R10 psnt"}, 32'(card_present), 32'(craw ^ pol));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51D0));
    // R11: reset state with busy inputs
    @(negedge clk);
    act = '1; bh[0] = 8'h03; bl[0] = 8'h00; addr = 12'h300; ior_n = 0;
    dirq = '1; isel[0] = 4'd5; craw = '1;
    step();
    chk("R11 cs", 32'(cs), 0);
    chk("R11 irq", 32'(irq_line), 0);
    chk("R11 psnt", 32'(card_present), 0);
    rst = 0;
    step();
    check_all("R1 dir hit");
    chk("R1 cs0", 32'(cs), 32'h1);
    // R4: base low bits ignored, offset passes
    bl[0] = 8'h07; addr = 12'h305; step();
    chk("R4 lowbits", 32'(cs), 32'h1);
    chk("R1 off5", 32'(reg_off), 5);
    // R2: inactive never decodes
    act[0] = 0; step();
    chk("R2 inactive cs", 32'(cs), 0);
    chk("R2 inactive irq", 32'(irq_line), 0);
    act[0] = 1;
    // R3: AEN suppresses
    aen = 1; step();
    chk("R3 aen cs", 32'(cs), 0);
    chk("R3 aen rd", 32'(io_rd), 0);
    aen = 0;
    // R4: base below 0x100 and above 0xFFF
    bh[0] = 8'h00; bl[0] = 8'h80; addr = 12'h080; step();
    chk("R4 below", 32'(cs), 0);
    bh[0] = 8'h13; bl[0] = 8'h00; addr = 12'h300; step();
    chk("R4 above", 32'(cs), 0);
    bh[0] = 8'h01; bl[0] = 8'h00; addr = 12'h100; step();
    chk("R4 min edge", 32'(cs), 32'h1);
    // R5: overlap priority
    bh[1] = 8'h01; bl[1] = 8'h00; bh[2] = 8'h01; bl[2] = 8'h00; step();
    chk("R5 overlap", 32'(cs), 32'h1);
    act[0] = 0; step();
    chk("R5 next", 32'(cs), 32'h2);
    // R6: write strobe
    ior_n = 1; iow_n = 0; step();
    chk("R6 wr", 32'(io_wr), 1);
    chk("R6 rd", 32'(io_rd), 0);
    // R7/R8: select 0 drives nothing
    act = '1; isel = '0; dsel = '0; ddrq = '1; step();
    chk("R7 sel0", 32'(irq_line), 0);
    chk("R8 sel0", 32'(drq_line), 0);
    dsel[1] = 4'd9; dsel[2] = 4'd3; step();
    chk("R8 sel9", 32'(drq_line), 32'h08);
    // R9: DMA ack and tc
    aen = 1; dack_n = 8'hF7; tc = 1; iow_n = 1; step();
    chk("R9 ack", 32'(dma_ack), 32'h4);
    chk("R9 tc", 32'(dma_tc), 32'h4);
    aen = 0; step();
    chk("R9 noaen", 32'(dma_ack), 0);
    // R10: polarity
    craw = 3'b010; pol = 3'b011; step();
    chk("R10 pol", 32'(card_present), 32'(3'b001));

    for (int it = 0; it < 600; it++) begin
      if (it % 16 == 0) begin
        for (int i = 0; i < N; i++) begin
          logic [15:0] b;
          b = ($urandom % 8 == 0) ? 16'($urandom) : 16'(16'h100 + $urandom % 16'hF00);
          bh[i] = b[15:8]; bl[i] = b[7:0];
          isel[i] = 4'($urandom); dsel[i] = 4'($urandom);
        end
        act = N'($urandom); pol = N'($urandom);
      end
      if ($urandom % 4 != 0) begin
        int d = $urandom % N;
        addr = {bh[d][3:0], bl[d][7:3], 3'($urandom)};
      end else addr = 12'($urandom);
      aen = ($urandom % 5 == 0);
      ior_n = 1'($urandom); iow_n = 1'($urandom);
      dack_n = 8'($urandom); tc = 1'($urandom);
      dirq = N'($urandom); ddrq = N'($urandom); craw = N'($urandom);
      step();
      check_all("rand");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule